// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two operands and produces the result together with four condition flags: negative, zero, carry and signed overflow. One select input picks addition or subtraction. Another turns on the with-carry form, in which an external carry bit stands in for the implicit constant of the operation.

Subtraction is formed as A plus the inverted B plus one, so the carry flag after a subtraction means that no borrow occurred. The operands are sampled on a clock edge when `in_valid` is high. Result and flags appear one cycle later, qualified by `out_valid`. They hold their values while no new operation arrives.

Top module: `adsub_flags`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `result` and all four flags read zero until the first accepted operation.
- R2: With `op_sub`=0 and `use_cin`=0, the cycle after `in_valid` is sampled high, `result` equals (A + B) modulo 2^WIDTH.
- R3: With `op_sub`=1 and `use_cin`=0, `result` equals (A − B) modulo 2^WIDTH, and `flag_c` is 1 exactly when A ≥ B as unsigned numbers (carry means no borrow).
- R4: For addition, `flag_c` is the carry out of bit WIDTH-1 of the full unsigned sum A + B + carry term.
- R5: For addition, `flag_v` is 1 exactly when the signed sum falls outside the signed range. This can happen only when both operands share a sign bit that the result does not have.
- R6: For subtraction, `flag_v` is 1 exactly when the signed difference falls outside the signed range. This can happen only when the operand signs differ and the result sign differs from A's sign.
- R7: `flag_n` equals the most significant bit of `result`.
- R8: `flag_z` is 1 exactly when every bit of `result` is 0.
- R9: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, `result` and the flags keep their previous values.
- R10: With `use_cin`=1, `carry_in` replaces the implicit carry term, which is 0 for addition and 1 for subtraction. Addition then gives A + B + `carry_in`, and subtraction gives A − B − (1 − `carry_in`). The flags follow the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| use_cin | input | 1 | 1 = use `carry_in` as the carry term |
| carry_in | input | 1 | External carry for the with-carry forms |
| opnd_a | input | WIDTH | First operand (minuend when subtracting) |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| out_valid | output | 1 | Result and flags updated from the previous cycle |
| result | output | WIDTH | Sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow on subtraction) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The operand properties assume that controls and operands are sampled only when `in_valid` is high. They also assume these inputs hold known values on those edges. The bench drives every input on the falling edge, so each sampled value is settled and defined. The sign-based overflow properties need no constraint on the operand values. The stimulus therefore combines the boundary operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in all pairs, under all six operation forms, with random operands. Idle cycles carry random data to show that nothing is taken up while `in_valid` is low.

// File: rtl/adsub_flags.sv
module adsub_flags #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             use_cin,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin_eff;
  logic [WIDTH:0]   sum_ext;
  logic             ovf;

  assign b_eff   = op_sub ? ~opnd_b : opnd_b;
  assign cin_eff = use_cin ? carry_in : op_sub;
  assign sum_ext = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
  assign ovf     = (opnd_a[MSB] == b_eff[MSB]) && (sum_ext[MSB] != opnd_a[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum_ext[MSB:0];
        flag_n <= sum_ext[MSB];
        flag_z <= ~|sum_ext[MSB:0];
        flag_c <= sum_ext[WIDTH];
        flag_v <= ovf;
      end
    end
  end
endmodule

// File: rtl/adsub_flags_chk.sv
module adsub_flags_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             op_sub,
  input logic             use_cin,
  input logic             carry_in,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] plain_sum;
  logic             a_ge_b;
  assign plain_sum = opnd_a + opnd_b;
  assign a_ge_b    = (opnd_a >= opnd_b);

  p_add_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sub && !use_cin) |=> (result == $past(plain_sum)));

  p_sub_nob_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && !use_cin) |=> (flag_c == $past(a_ge_b)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sub && (opnd_a[MSB] != opnd_b[MSB])) |=> !flag_v);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && (opnd_a[MSB] == opnd_b[MSB])) |=> !flag_v);

  p_neg_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_n == result[MSB]));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0)));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c) && $stable(flag_v)));
endmodule

bind adsub_flags adsub_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_adsub_flags.sv
module test_adsub_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0, use_cin = 1'b0, carry_in = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid, flag_n, flag_z, flag_c, flag_v;
  logic [31:0] result;

  int tests = 0, fails = 0;

  logic        e_valid = 1'b0, e_n = 1'b0, e_z = 1'b0, e_c = 1'b0, e_v = 1'b0;
  logic [31:0] e_res = '0;
  logic        last_sub = 1'b0, last_uc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adsub_flags #(.WIDTH(32)) i_adsub_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .use_cin(use_cin), .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    string rr, cr, vr;
    rr = last_sub ? "R3" : "R2";
    cr = last_sub ? "R3" : "R4";
    vr = last_sub ? "R6" : "R5";
    if (last_uc) begin
      rr = {rr, "/R10"};
      cr = {cr, "/R10"};
      vr = {vr, "/R10"};
    end
    chk("R9 out_valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk({rr, " result"}, result, e_res);
    chk({cr, " carry"}, {31'd0, flag_c}, {31'd0, e_c});
    chk({vr, " overflow"}, {31'd0, flag_v}, {31'd0, e_v});
    chk("R7 negative", {31'd0, flag_n}, {31'd0, e_n});
    chk("R8 zero", {31'd0, flag_z}, {31'd0, e_z});
  endtask

  task automatic step(logic v, logic sub, logic uc, logic ci, logic [31:0] a, logic [31:0] b);
    longint sa, sb, sres, ua, ub, ures, cterm;
    @(negedge clk);
    check_all();
    in_valid = v; op_sub = sub; use_cin = uc; carry_in = ci; opnd_a = a; opnd_b = b;
    e_valid = v;
    if (v) begin
      cterm = uc ? longint'(ci) : (sub ? 1 : 0);
      ua = longint'(a); ub = longint'(b);
      sa = longint'($signed(a)); sb = longint'($signed(b));
      if (!sub) begin
        ures = ua + ub + cterm;
        sres = sa + sb + cterm;
        e_c = (ures > 64'hFFFF_FFFF);
      end else begin
        ures = ua - ub - (1 - cterm);
        sres = sa - sb - (1 - cterm);
        e_c = (ures >= 0);
      end
      e_res = ures[31:0];
      e_v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      e_n = e_res[31];
      e_z = (e_res == 32'd0);
      last_sub = sub; last_uc = uc;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] edges [4];
    edges[0] = 32'h0000_0000; edges[1] = 32'h7FFF_FFFF;
    edges[2] = 32'h8000_0000; edges[3] = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset result", result, 32'd0);
    chk("R1 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
    // Boundary pairs under add, sub, and the with-carry forms (R10)
    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          step(1'b1, m[0], m >= 2, m >= 4, edges[i], edges[j]);
        end
      end
    end
    // Equal operands and off-by-one subtraction around the no-borrow boundary (R3)
    step(1'b1, 1'b1, 1'b0, 1'b0, 32'd5, 32'd5);
    step(1'b1, 1'b1, 1'b0, 1'b0, 32'd4, 32'd5);
    step(1'b1, 1'b1, 1'b1, 1'b0, 32'd5, 32'd5);
    step(1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE, 32'd1);
    // Random operands, with idle cycles on random data (R9)
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom, $urandom);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h1);
    @(negedge clk);
    check_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule